// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block produces the bus cycles that a small 8-bit accumulator processor spends on fetching one operand. After a start request it walks through the opcode fetch, the operand bytes of the instruction, any zero-page pointer reads, any internal dummy reads, and finally the operand read. On each cycle it drives a 16-bit address and a tag that names the kind of cycle. The caller gives a mode code and the two index registers, and gets back a one-clock completion strobe that carries the operand byte.

Every address sum goes through a single 8-bit adder, used once per cycle at most. This has two costs. An index that is added to a zero-page base needs its own internal cycle. A carry out of the low byte of a full 16-bit address needs one more internal cycle, and that cycle happens only when the sum leaves the page. The program counter has its own incrementer and moves forward by one on every code fetch. It therefore ends each instruction at the address of the next instruction.

Top module: `ams_seq`

## Requirements
- R1: After reset the sequencer is idle (busy and done low). While idle, the address output shows the next code address, which starts at the RESET_PC parameter. The first code fetch after reset uses that address.
- R2: A start request is taken only while idle. A start request made while busy changes neither the running sequence nor the mode in use, and it does not queue a second instruction.
- R3: The cycle tag is encoded as 0 for a code fetch, 1 for a pointer read, 2 for an internal dummy read and 3 for the data read. Within one instruction the code fetches come first and the data read is last. An internal cycle is followed by a pointer read (indexed indirect only) or by the data read.
- R4: The mode code is encoded as 0 immediate, 1 zero page, 2 zero page+X, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 indexed indirect (zero page+X, then pointer), 7 indirect indexed (pointer, then +Y). With no page crossing these take 2, 3, 4, 4, 4, 4, 6 and 5 cycles.
- R5: Zero page+X spends one internal cycle that reads the unindexed base address {0x00, base}. The data address is {0x00, (base+X) mod 256}.
- R6: For absolute+X and absolute+Y the data address is the 16-bit sum of the address and the index. When the high byte changes, one internal cycle comes before the data read. That cycle presents the old high byte with the new low byte.
- R7: Both indirect modes read a two-byte pointer in two pointer cycles at zero page, low byte first. The second byte address is (first+1) mod 256. Indexed indirect first spends one internal cycle at {0x00, base}, and the pointer address is (base+X) mod 256.
- R8: Indirect indexed adds Y to the 16-bit pointer. When the high byte changes, one internal cycle at {old high, new low} comes before the data read.
- R9: Done is high for exactly one clock, in the last cycle of the instruction, with the operand output equal to the byte read in that cycle. The sequencer is idle in the next clock.
- R10: Code fetches of one instruction use consecutive addresses: 2 bytes for immediate, zero page and both indirect modes, 3 bytes for the absolute modes. The next instruction starts right after the last fetched byte.
- R11: No instruction completes in fewer than 2 cycles. Immediate completes on its second code fetch, and that fetch returns the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin one instruction |
| mode_i | input | 3 | Addressing mode code, taken with start |
| idx_x_i | input | DW | X index value |
| idx_y_i | input | DW | Y index value |
| rdata_i | input | DW | Read data for the current address |
| addr_o | output | AW | Bus address of the current cycle |
| cyc_o | output | 2 | Cycle kind tag |
| busy_o | output | 1 | An instruction is in progress |
| done_o | output | 1 | Last cycle of the instruction |
| operand_o | output | DW | Operand byte, valid with done |

## Verification
The bench builds the block with RESET_PC set to 0x04FE, so the second code fetch of the first instruction carries the program counter from one page into the next. Index capture at start and the ripple-carry adder are left at their defaults. The bench therefore also covers a mode input that changes in the middle of an instruction, and carries that travel through all eight adder bit positions. The chosen bases and indices reach every wrap case: the zero-page sum that wraps, the pointer whose second byte sits at address 0x0000, and page crossings in absolute+X, absolute+Y and indirect indexed.

// File: rtl/ams_pkg.sv
package ams_pkg;

   typedef enum logic [2:0] {
      M_IMM  = 3'd0,
      M_ZP   = 3'd1,
      M_ZPX  = 3'd2,
      M_ABS  = 3'd3,
      M_ABSX = 3'd4,
      M_ABSY = 3'd5,
      M_INDX = 3'd6,
      M_INDY = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      CY_CODE = 2'd0,
      CY_PTR  = 2'd1,
      CY_INTL = 2'd2,
      CY_DATA = 2'd3
   } cyc_e;

   typedef enum logic [3:0] {
      S_IDLE, S_OP, S_B1, S_B2, S_IDXW, S_PLO, S_PHI, S_FIX, S_DATA
   } st_e;

   typedef enum logic [1:0] {
      AS_PC, AS_ZP, AS_EA
   } asrc_e;

   typedef enum logic [1:0] {
      AA_ZPA, AA_LO, AA_HI
   } asel_e;

   typedef struct packed {
      logic  pc_inc;
      logic  lo_rd;
      logic  hi_rd;
      logic  zpa_rd;
      logic  hi_clr;
      logic  lo_sum;
      logic  hi_sum;
      logic  zpa_sum;
      logic  b_one;
      logic  idx_y;
      asel_e a_sel;
      asrc_e asrc;
   } ctl_t;

endpackage

// File: rtl/ams_adder.sv
module ams_adder #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         ci_i,
   output logic [W-1:0] sum_o,
   output logic         co_o
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = ci_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
            assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
         end
         assign co_o = c[W];
      end else begin : g_behav
         logic [W:0] full;
         assign full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
         assign sum_o = full[W-1:0];
         assign co_o  = full[W];
      end
   endgenerate

endmodule

// File: rtl/ams_fsm.sv
module ams_fsm
   import ams_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic [2:0] mode_i,
   input  logic       carry_i,
   output logic       accept_o,
   output logic       busy_o,
   output logic       done_o,
   output cyc_e       cyc_o,
   output ctl_t       ctl_o
);

   st_e    st, nxt;
   amode_e mode_q;
   logic   abs_idx;

   assign accept_o = (st == S_IDLE) && start_i;
   assign busy_o   = (st != S_IDLE);
   assign abs_idx  = (mode_q == M_ABSX) || (mode_q == M_ABSY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         mode_q <= M_IMM;
      end else begin
         st <= nxt;
         if (accept_o) mode_q <= amode_e'(mode_i);
      end
   end

   always_comb begin
      ctl_o  = '0;
      nxt    = st;
      cyc_o  = CY_CODE;
      done_o = 1'b0;
      case (st)
         S_IDLE: begin
            if (start_i) nxt = S_OP;
         end
         S_OP: begin
            ctl_o.pc_inc = 1'b1;
            nxt          = S_B1;
         end
         S_B1: begin
            ctl_o.pc_inc = 1'b1;
            ctl_o.lo_rd  = 1'b1;
            ctl_o.zpa_rd = 1'b1;
            ctl_o.hi_clr = 1'b1;
            case (mode_q)
               M_IMM: begin
                  done_o = 1'b1;
                  nxt    = S_IDLE;
               end
               M_ZP:          nxt = S_DATA;
               M_ZPX, M_INDX: nxt = S_IDXW;
               M_INDY:        nxt = S_PLO;
               default:       nxt = S_B2;
            endcase
         end
         S_B2: begin
            ctl_o.pc_inc = 1'b1;
            ctl_o.hi_rd  = 1'b1;
            if (abs_idx) begin
               ctl_o.a_sel  = AA_LO;
               ctl_o.idx_y  = (mode_q == M_ABSY);
               ctl_o.lo_sum = 1'b1;
               nxt          = carry_i ? S_FIX : S_DATA;
            end else begin
               nxt = S_DATA;
            end
         end
         S_IDXW: begin
            ctl_o.asrc  = AS_ZP;
            ctl_o.a_sel = AA_ZPA;
            cyc_o       = CY_INTL;
            if (mode_q == M_INDX) begin
               ctl_o.zpa_sum = 1'b1;
               nxt           = S_PLO;
            end else begin
               ctl_o.lo_sum = 1'b1;
               nxt          = S_DATA;
            end
         end
         S_PLO: begin
            ctl_o.asrc    = AS_ZP;
            ctl_o.lo_rd   = 1'b1;
            ctl_o.a_sel   = AA_ZPA;
            ctl_o.b_one   = 1'b1;
            ctl_o.zpa_sum = 1'b1;
            cyc_o         = CY_PTR;
            nxt           = S_PHI;
         end
         S_PHI: begin
            ctl_o.asrc  = AS_ZP;
            ctl_o.hi_rd = 1'b1;
            cyc_o       = CY_PTR;
            if (mode_q == M_INDY) begin
               ctl_o.a_sel  = AA_LO;
               ctl_o.idx_y  = 1'b1;
               ctl_o.lo_sum = 1'b1;
               nxt          = carry_i ? S_FIX : S_DATA;
            end else begin
               nxt = S_DATA;
            end
         end
         S_FIX: begin
            ctl_o.asrc   = AS_EA;
            ctl_o.a_sel  = AA_HI;
            ctl_o.b_one  = 1'b1;
            ctl_o.hi_sum = 1'b1;
            cyc_o        = CY_INTL;
            nxt          = S_DATA;
         end
         S_DATA: begin
            ctl_o.asrc = AS_EA;
            cyc_o      = CY_DATA;
            done_o     = 1'b1;
            nxt        = S_IDLE;
         end
         default: nxt = S_IDLE;
      endcase
   end

endmodule

// File: rtl/ams_dp.sv
module ams_dp
   import ams_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          AW          = 16,
   parameter int unsigned RESET_PC    = 'h0200,
   parameter bit          LATCH_INDEX = 1'b1,
   parameter bit          RIPPLE      = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept_i,
   input  ctl_t          ctl_i,
   input  logic [DW-1:0] x_i,
   input  logic [DW-1:0] y_i,
   input  logic [DW-1:0] rdata_i,
   output logic [AW-1:0] addr_o,
   output logic          carry_o
);

   localparam int PADW = AW - DW;

   logic [AW-1:0] pc;
   logic [DW-1:0] lo, hi, zpa;
   logic [DW-1:0] xq, yq;
   logic [DW-1:0] add_a, add_b, add_s;

   generate
      if (LATCH_INDEX) begin : g_latch
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               xq <= '0;
               yq <= '0;
            end else if (accept_i) begin
               xq <= x_i;
               yq <= y_i;
            end
         end
      end else begin : g_live
         logic unused_accept;
         assign unused_accept = accept_i;
         assign xq = x_i;
         assign yq = y_i;
      end
   endgenerate

   always_comb begin
      case (ctl_i.a_sel)
         AA_LO:   add_a = lo;
         AA_HI:   add_a = hi;
         default: add_a = zpa;
      endcase
      if (ctl_i.b_one)      add_b = '0;
      else if (ctl_i.idx_y) add_b = yq;
      else                  add_b = xq;
   end

   ams_adder #(.W(DW), .RIPPLE(RIPPLE)) u_add (
      .a_i  (add_a),
      .b_i  (add_b),
      .ci_i (ctl_i.b_one),
      .sum_o(add_s),
      .co_o (carry_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= AW'(RESET_PC);
         lo  <= '0;
         hi  <= '0;
         zpa <= '0;
      end else begin
         if (ctl_i.pc_inc) pc <= pc + AW'(1);
         if (ctl_i.lo_rd)       lo <= rdata_i;
         else if (ctl_i.lo_sum) lo <= add_s;
         if (ctl_i.hi_clr)      hi <= '0;
         else if (ctl_i.hi_rd)  hi <= rdata_i;
         else if (ctl_i.hi_sum) hi <= add_s;
         if (ctl_i.zpa_rd)       zpa <= rdata_i;
         else if (ctl_i.zpa_sum) zpa <= add_s;
      end
   end

   always_comb begin
      case (ctl_i.asrc)
         AS_ZP:   addr_o = {{PADW{1'b0}}, zpa};
         AS_EA:   addr_o = {hi, lo};
         default: addr_o = pc;
      endcase
   end

endmodule

// File: rtl/ams_seq.sv
module ams_seq
   import ams_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          AW          = 16,
   parameter int unsigned RESET_PC    = 'h0200,
   parameter bit          LATCH_INDEX = 1'b1,
   parameter bit          RIPPLE      = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [2:0]    mode_i,
   input  logic [DW-1:0] idx_x_i,
   input  logic [DW-1:0] idx_y_i,
   input  logic [DW-1:0] rdata_i,
   output logic [AW-1:0] addr_o,
   output logic [1:0]    cyc_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] operand_o
);

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("ams_seq: address width must be twice the data width");
      end
      if (DW < 2 || AW > 31) begin : g_bad_range
         $error("ams_seq: data width below 2 or address width above 31");
      end
   endgenerate

   ctl_t ctl;
   cyc_e cyc;
   logic accept, carry;

   ams_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .mode_i  (mode_i),
      .carry_i (carry),
      .accept_o(accept),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .cyc_o   (cyc),
      .ctl_o   (ctl)
   );

   ams_dp #(
      .DW(DW), .AW(AW), .RESET_PC(RESET_PC),
      .LATCH_INDEX(LATCH_INDEX), .RIPPLE(RIPPLE)
   ) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept_i(accept),
      .ctl_i   (ctl),
      .x_i     (idx_x_i),
      .y_i     (idx_y_i),
      .rdata_i (rdata_i),
      .addr_o  (addr_o),
      .carry_o (carry)
   );

   assign cyc_o     = cyc;
   assign operand_o = done_o ? rdata_i : '0;

endmodule

// File: rtl/ams_seq_chk.sv
module ams_seq_chk #(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [DW-1:0] rdata_i,
   input logic [AW-1:0] addr_o,
   input logic [1:0]    cyc_o,
   input logic          busy_o,
   input logic          done_o,
   input logic [DW-1:0] operand_o
);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> !busy_o);

   assert_intl_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cyc_o == 2'd2) |=> (busy_o && (cyc_o == 2'd3 || cyc_o == 2'd1)));

   assert_data_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cyc_o == 2'd3) |-> done_o);

   assert_fix_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && $past(cyc_o) == 2'd2 && busy_o && cyc_o == 2'd3
       && $past(addr_o[AW-1:DW]) != '0)
      |-> (addr_o == $past(addr_o) + (AW'(1) << DW)));

   assert_ptr_zp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cyc_o == 2'd1) |-> (addr_o[AW-1:DW] == '0));

   assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_o && operand_o == rdata_i));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);

   assert_code_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_o) && $past(cyc_o) == 2'd0 && busy_o && cyc_o == 2'd0)
      |-> (addr_o == $past(addr_o) + AW'(1)));

   assert_min_two_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !done_o);

endmodule

bind ams_seq ams_seq_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .rdata_i  (rdata_i),
   .addr_o   (addr_o),
   .cyc_o    (cyc_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .operand_o(operand_o)
);

// File: tb/sim_ams_seq.sv
module sim_ams_seq;

   localparam int CLK_PERIOD = 10;
   localparam int PC0        = 'h04FE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [7:0]  xr = 8'h00, yr = 8'h00;
   logic [15:0] addr;
   logic [1:0]  cyc;
   logic        busy, done;
   logic [7:0]  operand, rdata;
   logic [7:0]  mem [0:65535];

   int n_cmp = 0, n_bad = 0;
   logic [15:0] exp_pc;
   logic [15:0] e_addr [10];
   logic [1:0]  e_cyc [10];
   int          e_n;
   logic [7:0]  e_op;
   int          e_len;

   assign rdata = mem[addr];

   always #(CLK_PERIOD/2) clk = ~clk;

   ams_seq #(.RESET_PC(PC0)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
      .idx_x_i(xr), .idx_y_i(yr), .rdata_i(rdata),
      .addr_o(addr), .cyc_o(cyc), .busy_o(busy), .done_o(done),
      .operand_o(operand)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [15:0] a, input logic [1:0] c);
      e_addr[e_n] = a;
      e_cyc[e_n]  = c;
      e_n++;
   endtask

   task automatic build(input logic [2:0] m);
      logic [15:0] p, base, ea;
      logic [7:0]  b1, b2, z, iv;
      p  = exp_pc;
      b1 = mem[p + 16'd1];
      b2 = mem[p + 16'd2];
      ea = 16'h0000;
      e_n = 0;
      push(p, 2'd0);
      push(p + 16'd1, 2'd0);
      case (m)
         3'd1: begin ea = {8'h00, b1}; push(ea, 2'd3); end
         3'd2: begin
            push({8'h00, b1}, 2'd2);
            z = b1 + xr;
            ea = {8'h00, z};
            push(ea, 2'd3);
         end
         3'd3: begin push(p + 16'd2, 2'd0); ea = {b2, b1}; push(ea, 2'd3); end
         3'd4, 3'd5: begin
            push(p + 16'd2, 2'd0);
            iv = (m == 3'd4) ? xr : yr;
            ea = {b2, b1} + {8'h00, iv};
            if (ea[15:8] != b2) push({b2, ea[7:0]}, 2'd2);
            push(ea, 2'd3);
         end
         3'd6: begin
            push({8'h00, b1}, 2'd2);
            z = b1 + xr;
            push({8'h00, z}, 2'd1);
            push({8'h00, z + 8'd1}, 2'd1);
            ea = {mem[{8'h00, z + 8'd1}], mem[{8'h00, z}]};
            push(ea, 2'd3);
         end
         3'd7: begin
            push({8'h00, b1}, 2'd1);
            push({8'h00, b1 + 8'd1}, 2'd1);
            base = {mem[{8'h00, b1 + 8'd1}], mem[{8'h00, b1}]};
            ea = base + {8'h00, yr};
            if (ea[15:8] != base[15:8]) push({base[15:8], ea[7:0]}, 2'd2);
            push(ea, 2'd3);
         end
         default: ;
      endcase
      e_op  = (m == 3'd0) ? b1 : mem[ea];
      e_len = (m >= 3'd3 && m <= 3'd5) ? 3 : 2;
   endtask

   task automatic prog(input logic [7:0] b1v, input logic [7:0] b2v);
      mem[exp_pc]          = 8'hEA;
      mem[exp_pc + 16'd1]  = b1v;
      mem[exp_pc + 16'd2]  = b2v;
   endtask

   // Runs one instruction and compares every bus cycle with the expected list.
   task automatic run_instr(input string req, input logic [2:0] m, input bit stray);
      logic [15:0] g_addr [12];
      logic [1:0]  g_cyc [12];
      logic        g_done [12];
      logic [7:0]  g_op;
      int cnt = 0;
      bit fin = 0;
      build(m);
      @(negedge clk);
      mode  = m;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      g_op = 8'h00;
      for (int it = 0; it < 12 && !fin; it++) begin
         if (busy) begin
            g_addr[cnt] = addr;
            g_cyc[cnt]  = cyc;
            g_done[cnt] = done;
            if (done) begin fin = 1; g_op = operand; end
            cnt++;
         end
         if (stray && cnt == 1) begin
            start = 1'b1;
            mode  = ~m;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk("R4", "cycle count", cnt, e_n);
      chk("R9", "idle after done", busy, 1'b0);
      for (int k = 0; k < e_n && k < cnt; k++) begin
         chk(req, $sformatf("address of cycle %0d", k), g_addr[k], e_addr[k]);
         chk("R3", $sformatf("tag of cycle %0d", k), g_cyc[k], e_cyc[k]);
         chk("R9", $sformatf("done in cycle %0d", k), g_done[k], (k == e_n - 1));
      end
      chk("R9", "operand", g_op, e_op);
      exp_pc = exp_pc + 16'(e_len);
      @(negedge clk);
      chk("R10", "idle address is next code address", addr, exp_pc);
      chk("R2", "no queued instruction", busy, 1'b0);
   endtask

   task automatic t_reset;
      chk("R1", "busy after reset", busy, 1'b0);
      chk("R1", "done after reset", done, 1'b0);
      chk("R1", "idle address", addr, PC0);
   endtask

   task automatic t_imm;
      prog(8'h3C, 8'h00);
      run_instr("R11", 3'd0, 1'b0);
   endtask

   task automatic t_zp;
      prog(8'h42, 8'h00);
      mem[16'h0042] = 8'h91;
      run_instr("R4", 3'd1, 1'b0);
   endtask

   task automatic t_zpx_wrap;
      xr = 8'h20;
      prog(8'hF0, 8'h00);
      mem[16'h0010] = 8'hA5;
      run_instr("R5", 3'd2, 1'b0);
   endtask

   task automatic t_abs;
      prog(8'h34, 8'h12);
      mem[16'h1234] = 8'h5E;
      run_instr("R10", 3'd3, 1'b0);
   endtask

   task automatic t_absx_same_page;
      xr = 8'h10;
      prog(8'h20, 8'h30);
      mem[16'h3030] = 8'h66;
      run_instr("R6", 3'd4, 1'b0);
   endtask

   task automatic t_absx_cross;
      xr = 8'hF0;
      prog(8'h20, 8'h30);
      mem[16'h3110] = 8'h77;
      mem[16'h3010] = 8'h11;
      run_instr("R6", 3'd4, 1'b0);
   endtask

   task automatic t_absy_cross;
      yr = 8'h81;
      prog(8'h80, 8'h40);
      mem[16'h4101] = 8'h2B;
      mem[16'h4001] = 8'h33;
      run_instr("R6", 3'd5, 1'b0);
   endtask

   task automatic t_indx_wrap;
      xr = 8'h01;
      prog(8'hFE, 8'h00);
      mem[16'h00FF] = 8'h78;
      mem[16'h0000] = 8'h56;
      mem[16'h5678] = 8'hC3;
      run_instr("R7", 3'd6, 1'b0);
   endtask

   task automatic t_indy_same_page;
      yr = 8'h05;
      prog(8'h60, 8'h00);
      mem[16'h0060] = 8'h00;
      mem[16'h0061] = 8'h70;
      mem[16'h7005] = 8'h9A;
      run_instr("R8", 3'd7, 1'b0);
   endtask

   task automatic t_indy_cross;
      yr = 8'hFF;
      prog(8'h62, 8'h00);
      mem[16'h0062] = 8'h02;
      mem[16'h0063] = 8'h71;
      mem[16'h7201] = 8'h4D;
      mem[16'h7101] = 8'hE0;
      run_instr("R8", 3'd7, 1'b0);
   endtask

   task automatic t_indy_ptr_wrap;
      yr = 8'h00;
      prog(8'hFF, 8'h00);
      run_instr("R7", 3'd7, 1'b0);
   endtask

   task automatic t_start_while_busy;
      prog(8'h42, 8'h00);
      mem[16'h0042] = 8'h19;
      run_instr("R2", 3'd1, 1'b1);
   endtask

   initial begin
      for (int i = 0; i < 65536; i++) mem[i] = 8'(i ^ (i >> 8) ^ 'h5A);
      exp_pc = 16'(PC0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_imm();
      t_zp();
      t_zpx_wrap();
      t_abs();
      t_absx_same_page();
      t_absx_cross();
      t_absy_cross();
      t_indx_wrap();
      t_indy_same_page();
      t_indy_cross();
      t_indy_ptr_wrap();
      t_start_while_busy();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule